// File: doc/BRIEF.md
# Approximate Compressor-Tree Multiplier

This block multiplies two unsigned N-bit operands (N = 8 by default) and returns a 2N-bit product one clock later. The AND-gate partial-product matrix is reduced in a Dadda-style height schedule. Most of the reduction uses 4:2 compressors, and full and half adders fill the gaps. A row-sum carry-propagate adder then forms the product, and an output register holds it. The block suits datapaths that can accept a small and bounded error in the low half of the product in return for a shallower and cheaper reduction tree.

Approximation is confined to the N least significant columns. In the first reduction stage, every low column that holds at least four bits spends exactly one cheap 4:2 compressor. Columns below N/2 use a kind whose sum output is always right. Columns from N/2 to N-1 use a kind whose carry output is always right, because their carries land nearest the exact upper half. All further reduction, and every column at or above N, is exact. The compile-time parameter `RECOVER` selects the error-recovery variant. In that variant, each approximate compressor raises a cheap flag, the flags are ORed together, and the result is added at weight 2^(N-1) in the final adder.

Top module: `mul_apx_top`

## Requirements
- R1: The product of the operands present at a rising clock edge appears on `prod_o` after that edge and is held until the next one. A synchronous active-high `rst` clears `prod_o` to zero.
- R2: If either operand is zero, `prod_o` is zero in both variants.
- R3: If either operand has at most one bit set, `prod_o` equals the exact product in both variants.
- R4: With `RECOVER` = 0, the signed deviation `prod_o` − a·b lies strictly between −2^(N+1) and +2^N for every operand pair.
- R5: With `RECOVER` = 1, the signed deviation `prod_o` − a·b lies strictly between −2^(N+1) and +2^N + 2^(N-1) for every operand pair.
- R6: For the same operands, the recovery variant's product equals the basic variant's product or that product plus 2^(N-1). At least one operand pair (both operands all ones) makes the two variants differ.
- R7: With `RECOVER` = 0, the product differs from the exact product for at least one operand pair, so the low columns are really approximated.
- R8: Let the exact product modulo 2^(N+2) lie in the range [2^(N+1), 2^(N+2) − 2^N − 2^(N-1)). Then product bits N+2 and above equal those of the exact product in both variants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the product register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the product register |
| a_i | input | N | Unsigned multiplicand |
| b_i | input | N | Unsigned multiplier |
| prod_o | output | 2N | Registered approximate product |

## Verification
The rare cases are inputs that make an approximate compressor see two or more ones in a column, because only those produce any error or raise a recovery flag. The ones needed fall in scattered bit patterns of both operands. No short directed list can reach them reliably, so the bench drives every one of the 2^(2N) operand pairs through the basic and the recovery instances side by side. For each pair it checks the signed deviation window, the fixed step between the two variants, and the upper product bits whenever the exact product sits far enough from a 2^(N+2) boundary. Directed passes with zero and single-bit operands pin down the cases where no compressor may err.

// File: rtl/mul_apx_pkg.sv
package mul_apx_pkg;

  // Output bundle shared by every reduction element.
  typedef struct packed {
    logic s;   // bit kept in the same column
    logic c;   // bit moved one column up
    logic co;  // second upward bit (exact 4:2 only)
    logic f;   // error flag (approximate kinds only)
  } cmp_t;

  function automatic cmp_t cell_ha(input logic x1, input logic x2);
    cmp_t r;
    r.s  = x1 ^ x2;
    r.c  = x1 & x2;
    r.co = 1'b0;
    r.f  = 1'b0;
    return r;
  endfunction

  function automatic cmp_t cell_fa(input logic x1, input logic x2, input logic x3);
    cmp_t r;
    r.s  = x1 ^ x2 ^ x3;
    r.c  = (x1 & x2) | (x1 & x3) | (x2 & x3);
    r.co = 1'b0;
    r.f  = 1'b0;
    return r;
  endfunction

  // Exact 4:2: x1+x2+x3+x4+ci == s + 2*(c + co).
  function automatic cmp_t cell_exact42(input logic x1, input logic x2, input logic x3,
                                        input logic x4, input logic ci);
    cmp_t r;
    logic s1;
    s1   = x1 ^ x2 ^ x3;
    r.co = (x1 & x2) | (x1 & x3) | (x2 & x3);
    r.s  = s1 ^ x4 ^ ci;
    r.c  = (s1 & x4) | (s1 & ci) | (x4 & ci);
    r.f  = 1'b0;
    return r;
  endfunction

  // Approximate 4:2 whose sum bit is always right; it can only under-count by 2.
  function automatic cmp_t cell_apx_sum(input logic x1, input logic x2, input logic x3,
                                        input logic x4);
    cmp_t r;
    r.s  = x1 ^ x2 ^ x3 ^ x4;
    r.c  = (x1 & x2) | (x3 & x4);
    r.co = 1'b0;
    r.f  = (x1 | x2) & (x3 | x4);
    return r;
  endfunction

  // Approximate 4:2 whose carry bit is always right; error lies in {+1,-1,-2}.
  function automatic cmp_t cell_apx_carry(input logic x1, input logic x2, input logic x3,
                                          input logic x4);
    cmp_t r;
    r.c  = (x1 & x2) | (x1 & x3) | (x1 & x4) | (x2 & x3) | (x2 & x4) | (x3 & x4);
    r.s  = (x1 | x2) ^ (x3 | x4);
    r.co = 1'b0;
    r.f  = x1 & x2 & x3 & x4;
    return r;
  endfunction

  // Number of Dadda height limits (2, 3, 4, 6, 9, ...) below height h.
  function automatic int dadda_steps(input int h);
    int d;
    int k;
    d = 2;
    k = 0;
    while (d < h) begin
      k = k + 1;
      d = (d * 3) / 2;
    end
    return k;
  endfunction

  function automatic int dadda_term(input int k);
    int d;
    d = 2;
    for (int i = 0; i < k; i++) d = (d * 3) / 2;
    return d;
  endfunction

  // Height limit for reduction stage s of a matrix of height h.
  function automatic int dadda_target(input int h, input int s);
    int n;
    n = dadda_steps(h);
    if (s >= n - 1) return 2;
    return dadda_term(n - 1 - s);
  endfunction

endpackage

// File: rtl/mul_apx_ppgen.sv
module mul_apx_ppgen #(
  parameter int N    = 8,
  parameter int COLS = 2 * N + 1,
  parameter int H    = N + 4
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [H-1:0] col_o [COLS],
  output int           cnt_o [COLS]
);

  // Column c gathers a[i]&b[j] with i+j == c, ordered by ascending i.
  always_comb begin
    for (int c = 0; c < COLS; c++) begin
      col_o[c] = '0;
      cnt_o[c] = 0;
    end
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        col_o[i+j][cnt_o[i+j]] = a_i[i] & b_i[j];
        cnt_o[i+j]             = cnt_o[i+j] + 1;
      end
    end
  end

endmodule

// File: rtl/mul_apx_stage.sv
module mul_apx_stage
  import mul_apx_pkg::*;
#(
  parameter int N      = 8,
  parameter int COLS   = 2 * N + 1,
  parameter int H      = N + 4,
  parameter int TARGET = 2,
  parameter bit FIRST  = 1'b0
) (
  input  logic [H-1:0] col_i [COLS],
  input  int           cnt_i [COLS],
  output logic [H-1:0] col_o [COLS],
  output int           cnt_o [COLS],
  output logic         flag_o
);

  localparam int SPLIT = N / 2;   // low columns at or above this use the carry-exact kind

  always_comb begin
    int           rem;
    int           pos;
    int           excess;
    int           take;
    int           cn;
    logic         have;
    logic         two;
    cmp_t         r;
    logic [H+4:0] w;

    for (int c = 0; c < COLS; c++) begin
      col_o[c] = '0;
      cnt_o[c] = 0;
    end
    flag_o = 1'b0;

    // Ascending order: carries from column c-1 already sit in cnt_o[c].
    for (int c = 0; c < COLS; c++) begin
      cn  = (c + 1 < COLS) ? c + 1 : c;
      pos = 0;
      rem = cnt_i[c];
      for (int k = 0; k < H; k++) begin
        w      = {5'b0, col_i[c]} >> pos;
        excess = cnt_o[c] + rem - TARGET;
        have   = 1'b0;
        two    = 1'b0;
        take   = 0;
        r      = '0;
        if (FIRST && (c < N) && (k == 0) && (rem >= 4)) begin
          // one approximate compressor per low column, first stage only
          if (c >= SPLIT) r = cell_apx_carry(w[0], w[1], w[2], w[3]);
          else            r = cell_apx_sum(w[0], w[1], w[2], w[3]);
          have   = 1'b1;
          take   = 4;
          flag_o = flag_o | r.f;
        end else if ((excess > 0) && (rem >= 2)) begin
          have = 1'b1;
          if ((rem >= 4) && (excess >= 3)) begin
            take = ((rem >= 5) && (excess >= 4)) ? 5 : 4;
            r    = cell_exact42(w[0], w[1], w[2], w[3], (take == 5) ? w[4] : 1'b0);
            two  = 1'b1;
          end else if ((rem >= 3) && (excess >= 2)) begin
            r    = cell_fa(w[0], w[1], w[2]);
            take = 3;
          end else begin
            r    = cell_ha(w[0], w[1]);
            take = 2;
          end
        end
        if (have) begin
          pos = pos + take;
          rem = rem - take;
          if (cnt_o[c] < H) begin
            col_o[c][cnt_o[c]] = r.s;
            cnt_o[c]           = cnt_o[c] + 1;
          end
          if ((c + 1 < COLS) && (cnt_o[cn] < H)) begin
            col_o[cn][cnt_o[cn]] = r.c;
            cnt_o[cn]            = cnt_o[cn] + 1;
          end
          if (two && (c + 1 < COLS) && (cnt_o[cn] < H)) begin
            col_o[cn][cnt_o[cn]] = r.co;
            cnt_o[cn]            = cnt_o[cn] + 1;
          end
        end
      end
      // untouched bits pass straight to the next stage
      for (int k = 0; k < H; k++) begin
        if ((k >= pos) && (k < cnt_i[c]) && (cnt_o[c] < H)) begin
          col_o[c][cnt_o[c]] = col_i[c][k];
          cnt_o[c]           = cnt_o[c] + 1;
        end
      end
    end
  end

endmodule

// File: rtl/mul_apx_cpa.sv
module mul_apx_cpa #(
  parameter int N       = 8,
  parameter int COLS    = 2 * N + 1,
  parameter int H       = N + 4,
  parameter bit RECOVER = 1'b0
) (
  input  logic [H-1:0]   col_i [COLS],
  input  int             cnt_i [COLS],
  input  logic           corr_i,
  output logic [2*N-1:0] sum_o
);

  localparam int W = 2 * N;

  logic [W-1:0] acc;
  logic         unused_top;

  // Adds every remaining row; rows past each column's height are zero.
  always_comb begin
    logic [W-1:0] row;
    acc = '0;
    for (int r = 0; r < H; r++) begin
      for (int c = 0; c < W; c++) row[c] = (r < cnt_i[c]) ? col_i[c][r] : 1'b0;
      acc = acc + row;
    end
  end

  // Column 2N always sums to zero because the product fits in 2N bits.
  assign unused_top = (^col_i[COLS-1]) ^ (cnt_i[COLS-1] != 0);

  generate
    if (RECOVER) begin : g_rec
      assign sum_o = acc + (W'(corr_i) << (N - 1));
    end else begin : g_basic
      logic unused_corr;
      assign unused_corr = corr_i;
      assign sum_o       = acc;
    end
  endgenerate

endmodule

// File: rtl/mul_apx_top.sv
module mul_apx_top
  import mul_apx_pkg::*;
#(
  parameter int N       = 8,
  parameter bit RECOVER = 1'b0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic [2*N-1:0] prod_o
);

  localparam int W    = 2 * N;
  localparam int COLS = W + 1;
  localparam int H    = N + 4;
  localparam int NST  = dadda_steps(N) + 1;

  logic [H-1:0] pp_col [COLS];
  int           pp_cnt [COLS];
  logic [NST-1:0] flg;
  logic [W-1:0]   prod_d;

  mul_apx_ppgen #(.N(N), .COLS(COLS), .H(H)) u_pp (
    .a_i   (a_i),
    .b_i   (b_i),
    .col_o (pp_col),
    .cnt_o (pp_cnt)
  );

  generate
    for (genvar s = 0; s < NST; s++) begin : g_stage
      logic [H-1:0] col_in  [COLS];
      int           cnt_in  [COLS];
      logic [H-1:0] col_n   [COLS];
      int           cnt_n   [COLS];
      logic         flag_n;
      if (s == 0) begin : g_src
        assign col_in = pp_col;
        assign cnt_in = pp_cnt;
      end else begin : g_src
        assign col_in = g_stage[s-1].col_n;
        assign cnt_in = g_stage[s-1].cnt_n;
      end
      mul_apx_stage #(
        .N(N), .COLS(COLS), .H(H),
        .TARGET(dadda_target(N, s)),
        .FIRST(s == 0)
      ) u_st (
        .col_i  (col_in),
        .cnt_i  (cnt_in),
        .col_o  (col_n),
        .cnt_o  (cnt_n),
        .flag_o (flag_n)
      );
      assign flg[s] = flag_n;
    end
  endgenerate

  mul_apx_cpa #(.N(N), .COLS(COLS), .H(H), .RECOVER(RECOVER)) u_cpa (
    .col_i  (g_stage[NST-1].col_n),
    .cnt_i  (g_stage[NST-1].cnt_n),
    .corr_i (|flg),
    .sum_o  (prod_d)
  );

  always_ff @(posedge clk) begin
    if (rst) prod_o <= '0;
    else     prod_o <= prod_d;
  end

endmodule

// File: rtl/mul_apx_chk.sv
module mul_apx_chk #(
  parameter int N       = 8,
  parameter bit RECOVER = 1'b0
) (
  input logic           clk,
  input logic           rst,
  input logic [N-1:0]   a_i,
  input logic [N-1:0]   b_i,
  input logic [2*N-1:0] prod_o
);

  localparam int W        = 2 * N;
  localparam int LOW_LIM  = -(2 ** (N + 1));
  localparam int HIGH_LIM = RECOVER ? (2 ** N + 2 ** (N - 1)) : (2 ** N);

  logic [W-1:0]        exp_q;
  logic                live_q;
  logic signed [W+1:0] diff;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= 1'b0;
      exp_q  <= '0;
    end else begin
      live_q <= 1'b1;
      exp_q  <= W'(a_i) * W'(b_i);
    end
  end

  assign diff = $signed({2'b00, prod_o}) - $signed({2'b00, exp_q});

  p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (prod_o == '0));

  p_zero_operand_r2: assert property (@(posedge clk) disable iff (rst)
    ((a_i == '0) || (b_i == '0)) |=> (prod_o == '0));

  p_single_bit_exact_r3: assert property (@(posedge clk) disable iff (rst)
    ($onehot0(a_i) || $onehot0(b_i)) |=> (prod_o == W'($past(a_i)) * W'($past(b_i))));

  // R4 for the basic variant, R5 for the recovery variant
  p_err_bound_r4: assert property (@(posedge clk) disable iff (rst)
    live_q |-> ((diff > LOW_LIM) && (diff < HIGH_LIM)));

endmodule

bind mul_apx_top mul_apx_chk #(.N(N), .RECOVER(RECOVER)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .a_i    (a_i),
  .b_i    (b_i),
  .prod_o (prod_o)
);

// File: tb/mul_apx_top_test.sv
module mul_apx_top_test;

  localparam int N    = 8;
  localparam int W    = 2 * N;
  localparam int SPAN = 1 << N;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] a   = '0;
  logic [N-1:0] b   = '0;
  logic [W-1:0] prod_b;
  logic [W-1:0] prod_r;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  mul_apx_top #(.N(N), .RECOVER(1'b0)) uut (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .prod_o(prod_b)
  );

  mul_apx_top #(.N(N), .RECOVER(1'b1)) uut_rec (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .prod_o(prod_r)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a, b, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge with the result registered
  task automatic drive(input int x, input int y);
    a = N'(x);
    b = N'(y);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    a   = '1;
    b   = '1;
    repeat (3) @(negedge clk);
    check(prod_b == '0, "R1 reset basic", int'(prod_b), 0);
    check(prod_r == '0, "R1 reset recovery", int'(prod_r), 0);
    rst = 1'b0;
    a   = N'(3);
    b   = N'(4);
    #1;
    check(prod_b == '0, "R1 held before edge", int'(prod_b), 0);
    @(negedge clk);
    check(prod_b == W'(12), "R1 one-cycle latency", int'(prod_b), 12);
    check(prod_r == W'(12), "R1 one-cycle latency recovery", int'(prod_r), 12);
  endtask

  task automatic t_zero;
    for (int v = 0; v < SPAN; v++) begin
      drive(0, v);
      check(prod_b == '0, "R2 a=0 basic", int'(prod_b), 0);
      check(prod_r == '0, "R2 a=0 recovery", int'(prod_r), 0);
      drive(v, 0);
      check(prod_b == '0, "R2 b=0 basic", int'(prod_b), 0);
      check(prod_r == '0, "R2 b=0 recovery", int'(prod_r), 0);
    end
  endtask

  task automatic t_single_bit;
    for (int k = 0; k < N; k++) begin
      for (int v = 0; v < SPAN; v++) begin
        drive(1 << k, v);
        check(int'(prod_b) == (v << k), "R3 single-bit a basic", int'(prod_b), v << k);
        check(int'(prod_r) == (v << k), "R3 single-bit a recovery", int'(prod_r), v << k);
        drive(v, 1 << k);
        check(int'(prod_b) == (v << k), "R3 single-bit b basic", int'(prod_b), v << k);
        check(int'(prod_r) == (v << k), "R3 single-bit b recovery", int'(prod_r), v << k);
      end
    end
  endtask

  task automatic t_sweep;
    int dev_cnt = 0;
    int rec_cnt = 0;
    int lo_lim  = -(1 << (N + 1));
    int hi_b    = 1 << N;
    int hi_r    = (1 << N) + (1 << (N - 1));
    int step    = 1 << (N - 1);
    int win_hi  = (1 << (N + 2)) - (1 << N) - (1 << (N - 1));
    for (int x = 0; x < SPAN; x++) begin
      for (int y = 0; y < SPAN; y++) begin
        int ex;
        int eb;
        int er;
        int lowp;
        drive(x, y);
        ex = x * y;
        eb = int'(prod_b) - ex;
        er = int'(prod_r) - ex;
        check((eb > lo_lim) && (eb < hi_b), "R4 basic deviation window", int'(prod_b), ex);
        check((er > lo_lim) && (er < hi_r), "R5 recovery deviation window", int'(prod_r), ex);
        check((int'(prod_r) == int'(prod_b)) || (int'(prod_r) == int'(prod_b) + step),
              "R6 recovery step", int'(prod_r), int'(prod_b));
        if (eb != 0) dev_cnt++;
        if (prod_r != prod_b) rec_cnt++;
        lowp = ex % (1 << (N + 2));
        if ((lowp >= (1 << (N + 1))) && (lowp < win_hi)) begin
          check((int'(prod_b) >> (N + 2)) == (ex >> (N + 2)), "R8 upper bits basic",
                int'(prod_b) >> (N + 2), ex >> (N + 2));
          check((int'(prod_r) >> (N + 2)) == (ex >> (N + 2)), "R8 upper bits recovery",
                int'(prod_r) >> (N + 2), ex >> (N + 2));
        end
      end
    end
    check(dev_cnt > 0, "R7 basic deviates somewhere", dev_cnt, 1);
    check(rec_cnt > 0, "R6 variants differ somewhere", rec_cnt, 1);
    drive(SPAN - 1, SPAN - 1);
    check(prod_r != prod_b, "R6 all-ones operands differ", int'(prod_r), int'(prod_b));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_zero();
    t_single_bit();
    t_sweep();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule